// File: doc/BRIEF.md
# Qualified Performance Event Counter

This block accumulates performance events that a processor core reports once per clock cycle. Each cycle the core presents a small event count, the privilege level it is running at, and the coherence state of the cache line that the access touched. The block passes the count only when software has enabled that privilege level and that line state. The count is then turned into an increment in one of three ways: the qualified value is added as is, one is added when the event condition starts, or one is added on each cycle where the value exceeds a programmed threshold.

The 40-bit counter can be written through a simple register port. Software preloads it with the negated sample interval, so the counter wraps past its top value after the chosen number of events. On that wrap a sticky overflow flag is set, and a monitor interrupt is raised if interrupts are armed. Acknowledging the flag also disarms the interrupt. No further request is raised until software re-arms it, which gives the handler time to take its sample.

Register map (word address on `regAddr`): 0 control, 1 counter bits 31:0, 2 counter bits 39:32 (in bits 7:0), 3 status (bit 0 overflow flag). The control word holds: bit 0 global enable, bit 1 user-mode enable, bit 2 supervisor-mode enable, bits 6:3 line-state mask, bits 8:7 counting mode, bits 11:9 threshold, and bit 12 interrupt arm. Reads are combinational from `regAddr`.

Top module: `pmc_counter`

## Requirements
- R1: An event counts only when the privilege enable that matches `privMode` is set. `privMode`=0 is user mode and uses control bit 1. `privMode`=1 is supervisor mode and uses control bit 2.
- R2: An event counts only when the mask bit selected by `lineState` is set. The mask is control bits 6:3, and mask bit n matches `lineState`=n, with the encoding 0 invalid, 1 shared, 2 exclusive, 3 modified.
- R3: In sum mode (mode code 0, and the unused code 3), the counter adds the qualified 3-bit event value (0 to 7) at the clock edge where that value is presented.
- R4: In edge mode (code 1), the counter adds one only on a cycle where the qualified value is nonzero and was zero in the previous cycle. A condition that stays present adds nothing more.
- R5: In threshold mode (code 2), the counter adds one on each cycle where the qualified value is strictly greater than the 3-bit threshold. A value equal to the threshold adds nothing.
- R6: With control bit 0 (global enable) clear, the counter does not change except by register writes.
- R7: Writes to address 1 or 2 load the counter, and reads of those addresses return it. A counter write in the same cycle as an increment wins, and that cycle's increment is dropped.
- R8: An increment that carries out of bit 39 wraps the counter modulo 2^40 and sets the overflow flag. The flag holds until it is cleared by writing 1 to status bit 0. If an overflow and that clear fall in the same cycle, the flag stays set.
- R9: `pmiReq` is high exactly when the overflow flag and the interrupt arm bit (control bit 12) are both set. Writing 1 to status bit 0 also clears the arm bit. Later overflows then set the flag without a request until software sets the arm bit again.
- R10: After reset, the counter, the control word and the status read as zero, and `pmiReq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtCount | input | 3 | Event count reported this cycle |
| privMode | input | 1 | 0 user, 1 supervisor |
| lineState | input | 2 | Line state of the access: 0 I, 1 S, 2 E, 3 M |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register word address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| pmiReq | output | 1 | Performance monitor interrupt request |

## Verification
Every cycle, the assertions check these behaviours: no increment while global enable is clear or the privilege level is excluded, edge mode never adding on two cycles in a row, threshold mode adding at most one, counter writes landing exactly and suppressing the increment, and an overflow leaving a small wrapped value and a set flag. Other behaviours only the bench scenarios can show. These are the exact totals for each filter and mode combination, the strict threshold comparison at equality, the carry from a multi-event add across the wrap point, and the full disarm and re-arm sequence of the interrupt.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  localparam int PMC_DATA_W = 32;
  localparam int PMC_EVT_W  = 3;

  typedef enum logic [1:0] {
    MODE_SUM     = 2'd0,
    MODE_EDGE    = 2'd1,
    MODE_THRESH  = 2'd2,
    MODE_SUM_ALT = 2'd3
  } cnt_mode_e;

  typedef enum logic [1:0] {
    ADDR_CTRL   = 2'd0,
    ADDR_CNT_LO = 2'd1,
    ADDR_CNT_HI = 2'd2,
    ADDR_STATUS = 2'd3
  } reg_addr_e;

  // control word bit positions
  localparam int CTL_GLOBAL = 0;
  localparam int CTL_USER   = 1;
  localparam int CTL_SUPER  = 2;
  localparam int CTL_MASK   = 3;
  localparam int CTL_MODE   = 7;
  localparam int CTL_THR    = 9;
  localparam int CTL_ARM    = CTL_THR + PMC_EVT_W;
  localparam int CTL_USED   = CTL_ARM + 1;

  // strobes from control to datapath
  typedef struct packed {
    logic                  cntWrLo;
    logic                  cntWrHi;
    logic [PMC_DATA_W-1:0] wrData;
    logic                  incEn;
    logic [PMC_EVT_W-1:0]  incAmt;
  } pmc_strobe_t;

endpackage

// File: rtl/pmc_event_qual.sv
module pmc_event_qual
  import pmc_pkg::*;
#(
  parameter int EVT_W = PMC_EVT_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [EVT_W-1:0] evtCount,
  input  logic             privMode,
  input  logic [1:0]       lineState,
  input  logic             globalEn,
  input  logic             userEn,
  input  logic             supEn,
  input  logic [3:0]       stateMask,
  input  cnt_mode_e        mode,
  input  logic [EVT_W-1:0] thresh,
  output logic             incEn,
  output logic [EVT_W-1:0] incAmt
);

  logic             privOk;
  logic             stateOk;
  logic [EVT_W-1:0] qualVal;
  logic             condNow;
  logic             condPrev;
  logic [EVT_W-1:0] amt;

  assign privOk  = privMode ? supEn : userEn;
  assign stateOk = stateMask[lineState];
  assign qualVal = (privOk && stateOk) ? evtCount : '0;
  assign condNow = |qualVal;

  always_ff @(posedge clk) begin
    if (!rstN) condPrev <= 1'b0;
    else       condPrev <= condNow;
  end

  always_comb begin
    unique case (mode)
      MODE_EDGE:   amt = (condNow && !condPrev) ? EVT_W'(1) : '0;
      MODE_THRESH: amt = (qualVal > thresh)     ? EVT_W'(1) : '0;
      default:     amt = qualVal;
    endcase
  end

  assign incAmt = amt;
  assign incEn  = globalEn && (amt != '0);

  // R6
  no_count_disabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    !globalEn |-> !incEn);

  // R1
  no_count_excluded_priv_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((privMode && !supEn) || (!privMode && !userEn)) |-> !incEn);

  // R4
  edge_single_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_EDGE && incEn) |-> incAmt == EVT_W'(1));

  // R4
  edge_no_repeat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_EDGE && incEn) ##1 (mode == MODE_EDGE) |-> !incEn);

  // R5
  thresh_unit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_THRESH && incEn) |-> incAmt == EVT_W'(1));

endmodule

// File: rtl/pmc_ctrl.sv
module pmc_ctrl
  import pmc_pkg::*;
#(
  parameter int CNT_W  = 40,
  parameter int DATA_W = PMC_DATA_W,
  parameter int EVT_W  = PMC_EVT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [EVT_W-1:0]  evtCount,
  input  logic              privMode,
  input  logic [1:0]        lineState,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [CNT_W-1:0]  count,
  input  logic              ovfPulse,
  output pmc_strobe_t       strobe,
  output logic [DATA_W-1:0] regRdData,
  output logic              pmiReq
);

  localparam int HI_W = CNT_W - DATA_W;

  logic             globalEn;
  logic             userEn;
  logic             supEn;
  logic [3:0]       stateMask;
  cnt_mode_e        mode;
  logic [EVT_W-1:0] thresh;
  logic             intArm;
  logic             ovfFlag;

  logic             wrCtrl;
  logic             ackOvf;
  logic             incEn;
  logic [EVT_W-1:0] incAmt;
  logic [CTL_USED-1:0] ctrlWord;

  assign wrCtrl = regWrEn && (regAddr == ADDR_CTRL);
  assign ackOvf = regWrEn && (regAddr == ADDR_STATUS) && regWrData[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      globalEn  <= 1'b0;
      userEn    <= 1'b0;
      supEn     <= 1'b0;
      stateMask <= '0;
      mode      <= MODE_SUM;
      thresh    <= '0;
      intArm    <= 1'b0;
    end else if (wrCtrl) begin
      globalEn  <= regWrData[CTL_GLOBAL];
      userEn    <= regWrData[CTL_USER];
      supEn     <= regWrData[CTL_SUPER];
      stateMask <= regWrData[CTL_MASK +: 4];
      mode      <= cnt_mode_e'(regWrData[CTL_MODE +: 2]);
      thresh    <= regWrData[CTL_THR +: EVT_W];
      intArm    <= regWrData[CTL_ARM];
    end else if (ackOvf) begin
      intArm    <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)         ovfFlag <= 1'b0;
    else if (ovfPulse) ovfFlag <= 1'b1;
    else if (ackOvf)   ovfFlag <= 1'b0;
  end

  pmc_event_qual #(.EVT_W(EVT_W)) uQual (
    .clk       (clk),
    .rstN      (rstN),
    .evtCount  (evtCount),
    .privMode  (privMode),
    .lineState (lineState),
    .globalEn  (globalEn),
    .userEn    (userEn),
    .supEn     (supEn),
    .stateMask (stateMask),
    .mode      (mode),
    .thresh    (thresh),
    .incEn     (incEn),
    .incAmt    (incAmt)
  );

  always_comb begin
    strobe.cntWrLo = regWrEn && (regAddr == ADDR_CNT_LO);
    strobe.cntWrHi = regWrEn && (regAddr == ADDR_CNT_HI);
    strobe.wrData  = regWrData;
    strobe.incEn   = incEn;
    strobe.incAmt  = incAmt;
  end

  assign ctrlWord = {intArm, thresh, mode, stateMask, supEn, userEn, globalEn};

  always_comb begin
    unique case (regAddr)
      ADDR_CTRL:   regRdData = {{(DATA_W-CTL_USED){1'b0}}, ctrlWord};
      ADDR_CNT_LO: regRdData = count[DATA_W-1:0];
      ADDR_CNT_HI: regRdData = {{(DATA_W-HI_W){1'b0}}, count[CNT_W-1:DATA_W]};
      default:     regRdData = {{(DATA_W-1){1'b0}}, ovfFlag};
    endcase
  end

  assign pmiReq = ovfFlag && intArm;

  // R8
  ovf_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |=> ovfFlag);

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !ackOvf) |=> ovfFlag);

  // R9
  ack_drops_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackOvf && !wrCtrl) |=> !pmiReq);

endmodule

// File: rtl/pmc_datapath.sv
module pmc_datapath
  import pmc_pkg::*;
#(
  parameter int CNT_W  = 40,
  parameter int DATA_W = PMC_DATA_W,
  parameter int EVT_W  = PMC_EVT_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  pmc_strobe_t      strobe,
  output logic [CNT_W-1:0] count,
  output logic             ovfPulse
);

  localparam int HI_W  = CNT_W - DATA_W;
  localparam int SUM_W = CNT_W + 1;

  logic [CNT_W-1:0] cntQ;
  logic [SUM_W-1:0] sum;
  logic             anyWr;

  assign anyWr    = strobe.cntWrLo || strobe.cntWrHi;
  assign sum      = {1'b0, cntQ} + SUM_W'(strobe.incAmt);
  assign ovfPulse = strobe.incEn && !anyWr && sum[CNT_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (anyWr) begin
      if (strobe.cntWrLo) cntQ[DATA_W-1:0]     <= strobe.wrData;
      if (strobe.cntWrHi) cntQ[CNT_W-1:DATA_W] <= strobe.wrData[HI_W-1:0];
    end else if (strobe.incEn) begin
      cntQ <= sum[CNT_W-1:0];
    end
  end

  assign count = cntQ;

  // R7
  wr_lo_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntWrLo |=> count[DATA_W-1:0] == $past(strobe.wrData));

  // R7
  wr_hi_keeps_lo_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cntWrHi && !strobe.cntWrLo) |=> $stable(count[DATA_W-1:0]));

  // R6
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.incEn && !anyWr) |=> $stable(count));

  // R8
  wrap_small_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |=> count < CNT_W'(2 ** EVT_W));

endmodule

// File: rtl/pmc_counter.sv
module pmc_counter
  import pmc_pkg::*;
#(
  parameter int CNT_W  = 40,
  parameter int DATA_W = PMC_DATA_W,
  parameter int EVT_W  = PMC_EVT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [EVT_W-1:0]  evtCount,
  input  logic              privMode,
  input  logic [1:0]        lineState,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              pmiReq
);

  pmc_strobe_t      strobe;
  logic [CNT_W-1:0] count;
  logic             ovfPulse;

  pmc_ctrl #(.CNT_W(CNT_W), .DATA_W(DATA_W), .EVT_W(EVT_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .evtCount  (evtCount),
    .privMode  (privMode),
    .lineState (lineState),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .count     (count),
    .ovfPulse  (ovfPulse),
    .strobe    (strobe),
    .regRdData (regRdData),
    .pmiReq    (pmiReq)
  );

  pmc_datapath #(.CNT_W(CNT_W), .DATA_W(DATA_W), .EVT_W(EVT_W)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .count    (count),
    .ovfPulse (ovfPulse)
  );

  // R9
  request_needs_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    pmiReq |-> regAddr != ADDR_STATUS || regRdData[0]);

endmodule

// File: tb/tb_pmc_counter.sv
module tb_pmc_counter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  evtCount = '0;
  logic        privMode = 1'b0;
  logic [1:0]  lineState = '0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        pmiReq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pmc_counter dut (
    .clk(clk), .rstN(rstN), .evtCount(evtCount), .privMode(privMode),
    .lineState(lineState), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .pmiReq(pmiReq)
  );

  typedef struct packed {
    logic       g;
    logic [1:0] mode;
    logic [2:0] thr;
    logic       u;
    logic       s;
    logic [3:0] mask;
    logic       priv;
    logic [1:0] st;
    logic [2:0] evt;
    logic [3:0] cyc;
    logic [7:0] expv;
  } vec_t;

  localparam int NVEC = 15;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 2'd0, 3'd0, 1'b1, 1'b1, 4'hF, 1'b0, 2'd0, 3'd5, 4'd3, 8'd15}, // R3 sum
    '{1'b1, 2'd0, 3'd0, 1'b0, 1'b1, 4'hF, 1'b0, 2'd0, 3'd5, 4'd3, 8'd0},  // R1 user off
    '{1'b1, 2'd0, 3'd0, 1'b1, 1'b0, 4'hF, 1'b1, 2'd0, 3'd5, 4'd3, 8'd0},  // R1 sup off
    '{1'b1, 2'd0, 3'd0, 1'b0, 1'b1, 4'hF, 1'b1, 2'd2, 3'd2, 4'd4, 8'd8},  // R1 sup on
    '{1'b1, 2'd0, 3'd0, 1'b1, 1'b1, 4'h8, 1'b0, 2'd3, 3'd4, 4'd2, 8'd8},  // R2 M only
    '{1'b1, 2'd0, 3'd0, 1'b1, 1'b1, 4'h8, 1'b0, 2'd1, 3'd4, 4'd2, 8'd0},  // R2 S masked
    '{1'b1, 2'd0, 3'd0, 1'b1, 1'b1, 4'h2, 1'b0, 2'd1, 3'd1, 4'd5, 8'd5},  // R2 S only
    '{1'b1, 2'd1, 3'd0, 1'b1, 1'b1, 4'hF, 1'b0, 2'd0, 3'd3, 4'd4, 8'd1},  // R4 held
    '{1'b1, 2'd1, 3'd0, 1'b0, 1'b1, 4'hF, 1'b0, 2'd0, 3'd3, 4'd4, 8'd0},  // R4 filtered
    '{1'b1, 2'd2, 3'd2, 1'b1, 1'b1, 4'hF, 1'b0, 2'd0, 3'd3, 4'd4, 8'd4},  // R5 above
    '{1'b1, 2'd2, 3'd2, 1'b1, 1'b1, 4'hF, 1'b0, 2'd0, 3'd2, 4'd4, 8'd0},  // R5 equal
    '{1'b1, 2'd2, 3'd0, 1'b1, 1'b1, 4'hF, 1'b0, 2'd0, 3'd1, 4'd3, 8'd3},  // R5 thr 0
    '{1'b1, 2'd2, 3'd7, 1'b1, 1'b1, 4'hF, 1'b0, 2'd0, 3'd7, 4'd3, 8'd0},  // R5 thr 7
    '{1'b0, 2'd0, 3'd0, 1'b1, 1'b1, 4'hF, 1'b0, 2'd0, 3'd7, 4'd3, 8'd0},  // R6 off
    '{1'b1, 2'd3, 3'd0, 1'b1, 1'b1, 4'hF, 1'b0, 2'd0, 3'd7, 4'd2, 8'd14}  // R3 code 3
  };

  function automatic logic [31:0] mkCtrl(logic g, logic u, logic s, logic [3:0] mask,
                                         logic [1:0] mode, logic [2:0] thr, logic arm);
    return {19'd0, arm, thr, mode, mask, s, u, g};
  endfunction

  task automatic check(string req, logic [39:0] act, logic [39:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wrReg(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic pulse(logic [2:0] e, int n);
    evtCount = e;
    repeat (n) @(negedge clk);
    evtCount = '0;
  endtask

  task automatic preload(logic [31:0] lo, logic [7:0] hi);
    wrReg(2'd1, lo);
    wrReg(2'd2, {24'd0, hi});
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] ctl;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10 reset state
    rdReg(2'd0, rd); check("R10 ctrl", rd, 0);
    rdReg(2'd1, rd); check("R10 cnt lo", rd, 0);
    rdReg(2'd2, rd); check("R10 cnt hi", rd, 0);
    rdReg(2'd3, rd); check("R10 status", rd, 0);
    check("R10 pmi", pmiReq, 0);

    // table walk: qualification and modes
    for (int i = 0; i < NVEC; i++) begin
      evtCount = '0;
      preload(32'd0, 8'd0);
      wrReg(2'd0, mkCtrl(VECS[i].g, VECS[i].u, VECS[i].s, VECS[i].mask,
                         VECS[i].mode, VECS[i].thr, 1'b0));
      privMode = VECS[i].priv;
      lineState = VECS[i].st;
      pulse(VECS[i].evt, int'(VECS[i].cyc));
      rdReg(2'd1, rd);
      check($sformatf("R1-table vec%0d (R2 R3 R4 R5 R6)", i), rd, {24'd0, VECS[i].expv});
    end
    privMode = 1'b0; lineState = 2'd0;

    // R4 two separate starts
    preload(32'd0, 8'd0);
    wrReg(2'd0, mkCtrl(1, 1, 1, 4'hF, 2'd1, 3'd0, 0));
    pulse(3'd2, 2);
    @(negedge clk);
    pulse(3'd3, 1);
    rdReg(2'd1, rd); check("R4 two edges", rd, 2);

    // R8 R9 overflow and interrupt
    ctl = mkCtrl(1, 1, 1, 4'hF, 2'd0, 3'd0, 1);
    preload(32'hFFFF_FFFE, 8'hFF);
    wrReg(2'd0, ctl);
    pulse(3'd1, 1);
    rdReg(2'd1, rd); check("R8 below top lo", rd, 32'hFFFF_FFFF);
    rdReg(2'd3, rd); check("R8 no flag yet", rd, 0);
    check("R9 no pmi yet", pmiReq, 0);
    pulse(3'd1, 1);
    rdReg(2'd1, rd); check("R8 wrap lo", rd, 0);
    rdReg(2'd2, rd); check("R8 wrap hi", rd, 0);
    rdReg(2'd3, rd); check("R8 flag set", rd, 1);
    check("R9 pmi raised", pmiReq, 1);
    repeat (3) @(negedge clk);
    rdReg(2'd3, rd); check("R8 flag sticky", rd, 1);
    wrReg(2'd3, 32'd1);
    rdReg(2'd3, rd); check("R8 flag cleared", rd, 0);
    check("R9 pmi dropped", pmiReq, 0);
    rdReg(2'd0, rd); check("R9 arm cleared", rd, ctl & ~32'h1000);
    preload(32'hFFFF_FFFF, 8'hFF);
    pulse(3'd1, 1);
    rdReg(2'd3, rd); check("R8 flag again", rd, 1);
    check("R9 blocked while disarmed", pmiReq, 0);
    wrReg(2'd0, ctl);
    check("R9 re-armed", pmiReq, 1);
    wrReg(2'd3, 32'd1);

    // R8 carry from a multi-event add
    wrReg(2'd0, ctl);
    preload(32'hFFFF_FFFD, 8'hFF);
    pulse(3'd5, 1);
    rdReg(2'd1, rd); check("R8 carry lo", rd, 2);
    rdReg(2'd2, rd); check("R8 carry hi", rd, 0);
    rdReg(2'd3, rd); check("R8 carry flag", rd, 1);
    wrReg(2'd3, 32'd1);

    // R7 write beats increment (low word)
    @(negedge clk);
    evtCount = 3'd7; regWrEn = 1'b1; regAddr = 2'd1; regWrData = 32'd100;
    @(negedge clk);
    regWrEn = 1'b0; evtCount = '0;
    rdReg(2'd1, rd); check("R7 lo write wins", rd, 100);

    // R7 write beats increment (high word)
    preload(32'hFFFF_FFFF, 8'h00);
    @(negedge clk);
    evtCount = 3'd1; regWrEn = 1'b1; regAddr = 2'd2; regWrData = 32'd5;
    @(negedge clk);
    regWrEn = 1'b0; evtCount = '0;
    rdReg(2'd1, rd); check("R7 hi write lo kept", rd, 32'hFFFF_FFFF);
    rdReg(2'd2, rd); check("R7 hi write value", rd, 5);

    // R8 overflow beats clear in same cycle
    preload(32'hFFFF_FFFF, 8'hFF);
    @(negedge clk);
    evtCount = 3'd1; regWrEn = 1'b1; regAddr = 2'd3; regWrData = 32'd1;
    @(negedge clk);
    regWrEn = 1'b0; evtCount = '0;
    rdReg(2'd3, rd); check("R8 set beats clear", rd, 1);

    finishRun();
  end

endmodule